// File: doc/BRIEF.md
# Attention-Line Bus Acquiring Packet Sender

This block transmits one buffered packet over a shared serial data wire. The wire has a companion attention line, which is open-drain and pulled high, and which marks who owns the bus. When a send is requested, the block first listens to the attention line with its own driver released. A low level means another node already holds the bus, and the request ends at once with a busy code. A high level lets the block claim the bus by pulling the attention line low. It then waits two bit times so that listeners can settle.

Once it owns the bus, the block reads the packet length from the second buffer byte. It then offers every byte of the frame to a separate byte transmitter, one at a time and in buffer order. A frame is the address, the length, the payload and a trailing checksum byte, so it has length + 3 bytes. The byte transmitter handles bit timing and reports a collision for each byte it sends. A collision stops the packet at once. On success and on collision alike, the attention line is released in the same cycle as the one-cycle done pulse, which carries a two-bit result code.

Top module: `attn_pkt_sender`

## Requirements
- R1: After a synchronous reset, attn_drive_low_o, done_o, tx_start_o and buf_rd_en_o are all 0.
- R2: If the synchronised attention line reads low when sampled after a start request, the block never drives the attention line and never starts a byte. It ends with done_o high for one cycle and err_o = 2'b01 (busy).
- R3: If the sampled attention line is high, the block drives attn_drive_low_o high and keeps it high for every cycle in which tx_start_o is high. A new request issued in the cycle right after a done pulse must not be mistaken for a busy bus caused by the block's own earlier drive.
- R4: The first tx_start_o comes at least 2*BIT_CYCLES and at most 2*BIT_CYCLES+3 clock cycles after the cycle in which attn_drive_low_o first goes high.
- R5: The length L is the byte at buffer offset 1, and a buffer read returns data one cycle after buf_rd_en_o. Without a collision, exactly L+3 bytes are started, and done_o pulses with err_o = 2'b00 (none). This holds for L = 0 and for L = 255.
- R6: The k-th tx_start_o of a packet (counting from 0) presents buffer byte k on tx_byte_o. No new tx_start_o is issued until tx_fin_i has reported the byte before it.
- R7: If tx_fin_i arrives with tx_coll_i high, no further byte is started, and done_o pulses with err_o = 2'b10 (collision). When the collision is on byte c, exactly c+1 bytes have been started.
- R8: Each packet produces exactly one done pulse, one cycle long, and attn_drive_low_o is low in that cycle on both success and collision.
- R9: A start_i pulse while a packet is in progress is ignored. The running packet keeps its byte count, and no extra done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Send request pulse, taken only when idle |
| buf_rd_en_o | output | 1 | Packet buffer read enable |
| buf_addr_o | output | ADDR_W | Packet buffer byte address |
| buf_data_i | input | DATA_W | Buffer read data, valid one cycle after the read enable |
| tx_start_o | output | 1 | One-cycle request to the byte transmitter |
| tx_byte_o | output | DATA_W | Byte handed over together with tx_start_o |
| tx_fin_i | input | 1 | Byte transmitter finished the current byte |
| tx_coll_i | input | 1 | Collision flag, qualified by tx_fin_i |
| attn_drive_low_o | output | 1 | Pull the open-drain attention line low |
| attn_line_i | input | 1 | Attention line level as seen at the pad |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 2 | Result code with done_o: 00 none, 01 busy, 10 collision |

## Verification
The bench covers the busy case. A sender that ignores the attention line, or that samples it before the synchroniser has settled, would claim the bus and start bytes when it should report 01.

It also sends zero-length and maximum-length frames. A wrong overhead constant, or a counter too narrow for 258 bytes, would send the wrong number of bytes there.

Collisions are placed on the first byte and on a middle byte. A design that keeps going after the flag, or that forgets to release the attention line, would show extra starts, or a line still driven at done.

The bench also fires a start request right after a done pulse, and a second start in the middle of a packet. These expose a false busy caused by the block's own stale drive, and a restart that corrupts the running frame.

// File: rtl/attn_pkg.sv
package attn_pkg;

    // Result code reported together with the done pulse
    typedef enum logic [1:0] {
        ERR_NONE = 2'b00,
        ERR_BUSY = 2'b01,
        ERR_COLL = 2'b10
    } err_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SENSE,
        ST_GUARD,
        ST_RD,
        ST_GO,
        ST_WAIT,
        ST_FINISH
    } state_e;

    // Buffer offset holding the payload length
    localparam int unsigned LEN_OFFSET = 1;
    // Address byte, length byte and checksum byte added to the payload
    localparam int unsigned FRAME_OVERHEAD = 3;
    // Guard interval after claiming the bus, in bit times
    localparam int unsigned GUARD_BITS = 2;

    // Width needed for a frame byte count given the data width
    function automatic int unsigned frame_cnt_width(input int unsigned data_w);
        return data_w + 1;
    endfunction

endpackage

// File: rtl/attn_sync.sv
module attn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    // Resets to the idle (pulled-high) level of the line
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) ff_q <= '1;
                else     ff_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff_q <= '1;
                else     ff_q <= {ff_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/attn_guard_timer.sv
module attn_guard_timer #(
    parameter int unsigned CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else if (!expired_o) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign expired_o = run_i && (cnt_q == CNT_W'(CYCLES - 1));

    // R4: the guard only ends after it has been running for at least one cycle
    p_expire_after_run_r4: assert property (@(posedge clk) disable iff (rst)
        expired_o |-> $past(run_i));
endmodule

// File: rtl/attn_frame_counter.sv
module attn_frame_counter #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] len_i,
    input  logic              advance_i,
    output logic [CNT_W-1:0]  idx_o,
    output logic              last_o
);
    import attn_pkg::*;

    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] total_q;
    logic             loaded_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            total_q  <= '0;
            loaded_q <= 1'b0;
        end else begin
            if (clear_i) begin
                idx_q    <= '0;
                loaded_q <= 1'b0;
            end else if (advance_i) begin
                idx_q <= idx_q + CNT_W'(1);
            end
            if (load_i) begin
                total_q  <= CNT_W'(len_i) + CNT_W'(FRAME_OVERHEAD);
                loaded_q <= 1'b1;
            end
        end
    end

    assign idx_o  = idx_q;
    assign last_o = loaded_q && (idx_q == total_q - CNT_W'(1));

    // R5: the byte index never runs past the frame
    p_idx_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        loaded_q |-> (idx_q < total_q));
endmodule

// File: rtl/attn_pkt_sender.sv
module attn_pkt_sender #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 9,
    parameter int unsigned BIT_CYCLES  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              buf_rd_en_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    input  logic [DATA_W-1:0] buf_data_i,
    output logic              tx_start_o,
    output logic [DATA_W-1:0] tx_byte_o,
    input  logic              tx_fin_i,
    input  logic              tx_coll_i,
    output logic              attn_drive_low_o,
    input  logic              attn_line_i,
    output logic              done_o,
    output logic [1:0]        err_o
);
    import attn_pkg::*;

    localparam int unsigned CNT_W     = frame_cnt_width(DATA_W);
    localparam int unsigned GUARD_CYC = GUARD_BITS * BIT_CYCLES;
    localparam int unsigned SETTLE    = SYNC_STAGES + 1;
    localparam int unsigned SET_W     = $clog2(SETTLE + 1);

    state_e           state_q, state_d;
    err_e             err_q;
    logic             drive_q;
    logic             len_pend_q;
    logic [SET_W-1:0] settle_q;

    logic             sync_hi;
    logic             settle_done;
    logic             sense_ok;
    logic             guard_exp;
    logic [CNT_W-1:0] idx;
    logic             last;
    logic             advance;

    attn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (attn_line_i),
        .q_o (sync_hi)
    );

    attn_guard_timer #(.CYCLES(GUARD_CYC)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .run_i     (state_q == ST_GUARD),
        .expired_o (guard_exp)
    );

    attn_frame_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (sense_ok),
        .load_i    (len_pend_q),
        .len_i     (buf_data_i),
        .advance_i (advance),
        .idx_o     (idx),
        .last_o    (last)
    );

    assign settle_done = (state_q == ST_SENSE) && (settle_q == SET_W'(SETTLE - 1));
    assign sense_ok    = settle_done && sync_hi;
    assign advance     = (state_q == ST_WAIT) && tx_fin_i && !tx_coll_i && !last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SENSE;
            ST_SENSE:  if (settle_done) state_d = sync_hi ? ST_GUARD : ST_FINISH;
            ST_GUARD:  if (guard_exp) state_d = ST_RD;
            ST_RD:     state_d = ST_GO;
            ST_GO:     state_d = ST_WAIT;
            ST_WAIT:   if (tx_fin_i) state_d = (tx_coll_i || last) ? ST_FINISH : ST_RD;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            err_q      <= ERR_NONE;
            drive_q    <= 1'b0;
            len_pend_q <= 1'b0;
            settle_q   <= '0;
        end else begin
            state_q    <= state_d;
            len_pend_q <= sense_ok;
            case (state_q)
                ST_IDLE: settle_q <= '0;
                ST_SENSE: begin
                    if (!settle_done) settle_q <= settle_q + SET_W'(1);
                    if (settle_done) begin
                        if (sync_hi) begin
                            drive_q <= 1'b1;
                            err_q   <= ERR_NONE;
                        end else begin
                            err_q   <= ERR_BUSY;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tx_fin_i) begin
                        if (tx_coll_i) begin
                            err_q   <= ERR_COLL;
                            drive_q <= 1'b0;
                        end else if (last) begin
                            drive_q <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign buf_rd_en_o      = sense_ok || (state_q == ST_RD);
    assign buf_addr_o       = sense_ok ? ADDR_W'(LEN_OFFSET) : ADDR_W'(idx);
    assign tx_start_o       = (state_q == ST_GO);
    assign tx_byte_o        = tx_start_o ? buf_data_i : '0;
    assign attn_drive_low_o = drive_q;
    assign done_o           = (state_q == ST_FINISH);
    assign err_o            = done_o ? err_q : ERR_NONE;

    // R3: the bus is claimed only after the line was seen high
    p_claim_needs_idle_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(attn_drive_low_o) |-> $past(sync_hi));
    // R3: every byte goes out while the bus is held
    p_byte_under_claim_r3: assert property (@(posedge clk) disable iff (rst)
        tx_start_o |-> attn_drive_low_o);
    // R2: a busy result never follows a claim
    p_busy_no_claim_r2: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o == 2'b01) |-> !$past(attn_drive_low_o));
    // R2: only defined codes are reported
    p_err_legal_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (err_o != 2'b11));
    // R8: the line is released when done pulses
    p_release_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !attn_drive_low_o);
    // R8: the done pulse lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R6: a byte request is never repeated back to back
    p_one_start_r6: assert property (@(posedge clk) disable iff (rst)
        tx_start_o |=> !tx_start_o);
endmodule

// File: tb/attn_pkt_sender_bench.sv
module attn_pkt_sender_bench;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned ADDR_W     = 9;
    localparam int unsigned BIT_CYCLES = 16;
    localparam int         FIN_LAT    = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              buf_rd_en_o;
    logic [ADDR_W-1:0] buf_addr_o;
    logic [DATA_W-1:0] buf_data_i = '0;
    logic              tx_start_o;
    logic [DATA_W-1:0] tx_byte_o;
    logic              tx_fin_i = 1'b0;
    logic              tx_coll_i = 1'b0;
    logic              attn_drive_low_o;
    logic              attn_line_i;
    logic              done_o;
    logic [1:0]        err_o;

    logic              ext_low = 1'b0;
    logic [7:0]        mem [0:(1<<ADDR_W)-1];

    int checks = 0;
    int failures = 0;
    int coll_at = -1;

    always #4 clk = ~clk;

    // Wired-AND attention line with an external holder
    assign attn_line_i = ~(attn_drive_low_o | ext_low);

    attn_pkt_sender #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BIT_CYCLES(BIT_CYCLES), .SYNC_STAGES(2)
    ) u_attn_pkt_sender (
        .clk(clk), .rst(rst), .start_i(start_i),
        .buf_rd_en_o(buf_rd_en_o), .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
        .tx_start_o(tx_start_o), .tx_byte_o(tx_byte_o),
        .tx_fin_i(tx_fin_i), .tx_coll_i(tx_coll_i),
        .attn_drive_low_o(attn_drive_low_o), .attn_line_i(attn_line_i),
        .done_o(done_o), .err_o(err_o)
    );

    // Buffer with one cycle of read latency
    always @(posedge clk) begin
        if (buf_rd_en_o) buf_data_i <= mem[buf_addr_o];
    end

    // Byte transmitter model
    int pend = 0;
    int lat = 0;
    int rsp_idx = 0;
    always @(posedge clk) begin
        tx_fin_i  <= 1'b0;
        tx_coll_i <= 1'b0;
        if (rst) begin
            pend <= 0; lat <= 0; rsp_idx <= 0;
        end else begin
            if (done_o) rsp_idx <= 0;
            if (tx_start_o) begin
                pend <= 1; lat <= FIN_LAT;
            end else if (pend != 0) begin
                if (lat == 0) begin
                    tx_fin_i  <= 1'b1;
                    tx_coll_i <= (rsp_idx == coll_at);
                    pend      <= 0;
                    rsp_idx   <= rsp_idx + 1;
                end else begin
                    lat <= lat - 1;
                end
            end
        end
    end

    // Monitor, sampled away from the active edge
    int  cyc = 0;
    int  sent = 0;
    int  mism = 0;
    int  overlap = 0;
    int  unclaimed = 0;
    int  claim_seen = 0;
    int  claim_cyc = 0;
    int  gap = -1;
    int  done_cnt = 0;
    int  last_err = 0;
    int  drive_at_done = 0;
    logic prev_drive = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_drive <= attn_drive_low_o;
        if (attn_drive_low_o && !prev_drive) begin
            claim_seen <= 1;
            claim_cyc  <= cyc;
        end
        if (tx_start_o) begin
            if (sent == 0) gap <= cyc - claim_cyc;
            if (tx_byte_o != mem[sent]) mism <= mism + 1;
            if (pend != 0) overlap <= overlap + 1;
            if (!attn_drive_low_o) unclaimed <= unclaimed + 1;
            sent <= sent + 1;
        end
        if (done_o) begin
            done_cnt      <= done_cnt + 1;
            last_err      <= int'(err_o);
            drive_at_done <= int'(attn_drive_low_o);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(attn_drive_low_o == 1'b0, "R1 drive after reset", int'(attn_drive_low_o), 0);
        check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        check(tx_start_o == 1'b0, "R1 tx_start after reset", int'(tx_start_o), 0);
        check(buf_rd_en_o == 1'b0, "R1 read enable after reset", int'(buf_rd_en_o), 0);
    endtask

    // One packet: len payload bytes, collision on byte coll (-1 none),
    // busy bus, extra start mid-packet, idle cycles after done
    task automatic run_packet(input int len, input int coll, input bit busy,
                              input bit extra_start, input int idle_after, input string name);
        int d0;
        int w;
        int exp_err;
        int exp_sent;
        for (int k = 0; k < len + 3; k++) mem[k] = 8'((k * 37 + len * 11 + 5) & 255);
        mem[1]  = 8'(len);
        coll_at = coll;
        ext_low = busy;
        sent = 0; mism = 0; overlap = 0; unclaimed = 0; claim_seen = 0; gap = -1;
        d0 = done_cnt;
        if (busy) begin
            exp_err = 1; exp_sent = 0;
        end else if (coll >= 0) begin
            exp_err = 2; exp_sent = coll + 1;
        end else begin
            exp_err = 0; exp_sent = len + 3;
        end
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        w = 0;
        while (done_cnt == d0 && w < 20000) begin
            @(negedge clk);
            w++;
            start_i = (extra_start && w == 40);
        end
        start_i = 1'b0;
        check(done_cnt == d0 + 1, {"R8 done count ", name}, done_cnt - d0, 1);
        check(last_err == exp_err, {"R2/R5/R7 result code ", name}, last_err, exp_err);
        if (busy)
            check(sent == 0, {"R2 bytes on busy bus ", name}, sent, 0);
        else if (coll >= 0)
            check(sent == exp_sent, {"R7 bytes before abort ", name}, sent, exp_sent);
        else
            check(sent == exp_sent, {"R5 byte count ", name}, sent, exp_sent);
        check(mism == 0, {"R6 byte order ", name}, mism, 0);
        check(drive_at_done == 0, {"R8 line released at done ", name}, drive_at_done, 0);
        if (busy) begin
            check(claim_seen == 0, {"R2 no claim on busy bus ", name}, claim_seen, 0);
        end else begin
            check(claim_seen == 1, {"R3 claim seen ", name}, claim_seen, 1);
            check(unclaimed == 0, {"R3 byte without claim ", name}, unclaimed, 0);
            check(gap >= 2 * BIT_CYCLES && gap <= 2 * BIT_CYCLES + 3,
                  {"R4 guard gap ", name}, gap, 2 * BIT_CYCLES + 1);
            check(overlap == 0, {"R6 start before finish ", name}, overlap, 0);
        end
        ext_low = 1'b0;
        if (idle_after > 0) begin
            repeat (idle_after) @(negedge clk);
            check(done_cnt == d0 + 1, {"R9 no extra done ", name}, done_cnt - d0, 1);
            check(attn_drive_low_o == 1'b0, {"R8 line idle after ", name}, int'(attn_drive_low_o), 0);
        end
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < (1 << ADDR_W); k++) mem[k] = 8'h00;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        run_packet(5,   -1, 1'b0, 1'b0, 50, "len5");
        run_packet(0,   -1, 1'b0, 1'b0, 50, "len0");
        run_packet(255, -1, 1'b0, 1'b0, 50, "len255");
        run_packet(4,    0, 1'b0, 1'b0, 50, "coll_first");
        run_packet(6,    3, 1'b0, 1'b0, 50, "coll_mid");
        run_packet(3,   -1, 1'b1, 1'b0, 50, "busy");
        run_packet(10,  -1, 1'b0, 1'b1, 60, "restart_ignored_R9");
        run_packet(2,   -1, 1'b0, 1'b0, 0,  "b2b_first");
        run_packet(4,   -1, 1'b0, 1'b0, 50, "b2b_second_R3");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule